// File: doc/BRIEF.md
# RTC Integration Test Register Bank

This block holds the test-only registers of a real-time clock. It sits on a simple 32-bit register bus that has an address, a write enable, write data and combinational read data. A control register decides two things. It sets whether the clock's interrupt line is driven by the core or by a value that software stores. It also opens or closes two 32-bit windows onto the core's offset register and counter register.

When a window is open, a write to it sends a one-cycle load strobe and the written word to the core. A read from an open window returns the core's live value. A closed window drops writes and reads as zero. Readback of the output test register comes from after the interrupt multiplexer, so software sees the level that actually leaves the block. The counting logic of the clock and the bus bridge live elsewhere.

Top module: `rtc_test_regs`

## Requirements
- R1: After reset, the control register (offset 0x80) and the output test register (offset 0x88) hold zero. `count_load` and `offset_load` are low, and `itest_mode` is low.
- R2: A write to 0x80 stores bits [2:0]: bit 0 is the integration enable, bit 1 the count window enable and bit 2 the offset window enable. Bits [31:3] are ignored on write and read back as zero.
- R3: While control bit 0 is 1, `irq_out` equals bit 0 last written to 0x88, and `core_irq` has no effect on it. `itest_mode` mirrors control bit 0.
- R4: While control bit 0 is 0, `irq_out` follows `core_irq`, and the stored bit at 0x88 has no effect.
- R5: A read of 0x88 returns `irq_out` in bit 0, not the stored value, with bits [31:1] zero. Write bits [31:1] at 0x88 are ignored.
- R6: With control bit 1 set, a write to 0x90 raises `count_load` in the cycle after the write edge, with `count_load_data` equal to the written word. A read of 0x90 returns `core_count`.
- R7: With control bit 1 clear, a write to 0x90 raises no strobe, and a read of 0x90 returns zero.
- R8: With control bit 2 set, a write to 0x8C raises `offset_load` in the cycle after the write edge, with `offset_load_data` equal to the written word. A read of 0x8C returns `core_offset`.
- R9: With control bit 2 clear, a write to 0x8C raises no strobe, and a read of 0x8C returns zero.
- R10: Offset 0x84 and every unmapped address read as zero. Writes to them change no register and raise no strobe.
- R11: Each load strobe is high for exactly one cycle per permitted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| core_irq | input | 1 | Functional interrupt from the clock core |
| core_offset | input | 32 | Live offset register value of the core |
| core_count | input | 32 | Live counter value of the core |
| irq_out | output | 1 | Interrupt after the test multiplexer |
| itest_mode | output | 1 | Integration test mode indication to the core |
| offset_load | output | 1 | One-cycle strobe to load the core offset |
| offset_load_data | output | 32 | Value to load into the core offset |
| count_load | output | 1 | One-cycle strobe to load the core counter |
| count_load_data | output | 32 | Value to load into the core counter |

## Verification
Corrupt control state shows up at once on the ports. A wrong integration bit flips `irq_out` against `core_irq` in the same cycle. A wrong window bit turns a live read into zero, or a zero read into a live one, on the very next read. A wrong stored override appears on `irq_out` and in the 0x88 readback only while integration mode is on, so the bench sets the override with the mode off and then switches the mode on. A strobe fault appears one cycle after the write edge, either as a missing pulse, a pulse that lasts two cycles, or a pulse on the wrong window.

// File: rtl/rtc_test_regs.sv
module rtc_test_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_CTRL = 'h80,
  parameter logic [ADDR_W-1:0] A_ITIN = 'h84,
  parameter logic [ADDR_W-1:0] A_ITOUT = 'h88,
  parameter logic [ADDR_W-1:0] A_OFFS = 'h8C,
  parameter logic [ADDR_W-1:0] A_CNT = 'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_irq,
  input  logic [31:0]       core_offset,
  input  logic [31:0]       core_count,
  output logic              irq_out,
  output logic              itest_mode,
  output logic              offset_load,
  output logic [31:0]       offset_load_data,
  output logic              count_load,
  output logic [31:0]       count_load_data
);
  localparam int CW = 3;

  logic [CW-1:0] ctrl_q;
  logic          ovr_q;
  logic          count_en, offset_en;
  logic          wr_count, wr_offset;

  assign itest_mode = ctrl_q[0];
  assign count_en   = ctrl_q[1];
  assign offset_en  = ctrl_q[2];

  assign wr_count  = bus_we && bus_addr == A_CNT  && count_en;
  assign wr_offset = bus_we && bus_addr == A_OFFS && offset_en;

  assign irq_out = itest_mode ? ovr_q : core_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL)  ctrl_q <= bus_wdata[CW-1:0];
      if (bus_addr == A_ITOUT) ovr_q  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_load       <= 1'b0;
      offset_load      <= 1'b0;
      count_load_data  <= '0;
      offset_load_data <= '0;
    end else begin
      count_load  <= wr_count;
      offset_load <= wr_offset;
      if (wr_count)  count_load_data  <= bus_wdata;
      if (wr_offset) offset_load_data <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[CW-1:0] = ctrl_q;
      A_ITIN:  bus_rdata = '0;
      A_ITOUT: bus_rdata[0] = irq_out;
      A_OFFS:  if (offset_en) bus_rdata = core_offset;
      A_CNT:   if (count_en) bus_rdata = core_count;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_test_regs_chk.sv
module rtc_test_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_ITOUT = 'h88,
  parameter logic [ADDR_W-1:0] A_OFFS = 'h8C,
  parameter logic [ADDR_W-1:0] A_CNT = 'h90
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic              count_en,
  input logic              offset_en,
  input logic              count_load,
  input logic [31:0]       count_load_data,
  input logic              offset_load,
  input logic [31:0]       offset_load_data
);
  p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CNT && count_en) |=>
      (count_load && count_load_data == $past(bus_wdata)));

  p_cnt_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CNT && !count_en) |=> !count_load);

  p_off_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OFFS && offset_en) |=>
      (offset_load && offset_load_data == $past(bus_wdata)));

  p_off_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_OFFS && !offset_en) |-> bus_rdata == 32'h0);

  p_irq_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ITOUT) |-> bus_rdata == {31'h0, irq_out});

  p_strobe_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count_load |-> $past(bus_we && bus_addr == A_CNT));

  p_one_hot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({count_load, offset_load}));
endmodule

bind rtc_test_regs rtc_test_regs_chk #(
  .ADDR_W(ADDR_W), .A_ITOUT(A_ITOUT), .A_OFFS(A_OFFS), .A_CNT(A_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .count_en(count_en), .offset_en(offset_en),
  .count_load(count_load), .count_load_data(count_load_data),
  .offset_load(offset_load), .offset_load_data(offset_load_data)
);

// File: tb/rtc_test_regs_test.sv
`timescale 1ns/1ps
module rtc_test_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_irq = 1'b0;
  logic [31:0] core_offset = 32'hA5A5_0F0F;
  logic [31:0] core_count = 32'h1234_5678;
  logic        irq_out, itest_mode;
  logic        offset_load, count_load;
  logic [31:0] offset_load_data, count_load_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rtc_test_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq(core_irq),
    .core_offset(core_offset), .core_count(core_count), .irq_out(irq_out),
    .itest_mode(itest_mode), .offset_load(offset_load),
    .offset_load_data(offset_load_data), .count_load(count_load),
    .count_load_data(count_load_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h80, d); chk("R1 ctrl", d, 0);
    rd(8'h88, d); chk("R1 itout", d, 0);
    chk("R1 strobes", {30'h0, count_load, offset_load}, 0);
    chk("R1 mode", {31'h0, itest_mode}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h80, 32'hFFFF_FFF8); rd(8'h80, d); chk("R2 reserved", d, 0);
    wr(8'h80, 32'h0000_0007); rd(8'h80, d); chk("R2 all bits", d, 7);
    wr(8'h80, 32'h0000_0005); rd(8'h80, d); chk("R2 pattern", d, 5);
    wr(8'h80, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    core_irq = 1'b1;
    wr(8'h88, 0);
    #1 chk("R4 follow hi", {31'h0, irq_out}, 1);
    core_irq = 1'b0;
    wr(8'h88, 1);
    #1 chk("R4 follow lo", {31'h0, irq_out}, 0);
    rd(8'h88, d); chk("R5 readback mux", d, 0);
    wr(8'h80, 1);
    #1 chk("R3 override", {31'h0, irq_out}, 1);
    chk("R3 mode", {31'h0, itest_mode}, 1);
    core_irq = 1'b1;
    wr(8'h88, 32'hFFFF_FFFE);
    #1 chk("R3 override lo", {31'h0, irq_out}, 0);
    rd(8'h88, d); chk("R5 upper bits", d, 0);
    wr(8'h80, 0);
    rd(8'h88, d); chk("R5 readback func", d, 1);
    core_irq = 1'b0;
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(8'h80, 2);
    wr(8'h90, 32'hCAFE_0001);
    chk("R6 strobe", {31'h0, count_load}, 1);
    chk("R6 data", count_load_data, 32'hCAFE_0001);
    chk("R6 no offset strobe", {31'h0, offset_load}, 0);
    @(negedge clk);
    chk("R11 count pulse", {31'h0, count_load}, 0);
    rd(8'h90, d); chk("R6 read", d, core_count);
    core_count = 32'h0BAD_F00D;
    #1 chk("R6 live read", bus_rdata, 32'h0BAD_F00D);
    rd(8'h8C, d); chk("R9 offset closed", d, 0);
    wr(8'h8C, 32'h1111_2222);
    chk("R9 no strobe", {31'h0, offset_load}, 0);
    wr(8'h80, 0);
    wr(8'h90, 32'h5555_AAAA);
    chk("R7 no strobe", {31'h0, count_load}, 0);
    rd(8'h90, d); chk("R7 read zero", d, 0);
  endtask

  task automatic t_offset();
    logic [31:0] d;
    wr(8'h80, 4);
    wr(8'h8C, 32'h8000_0001);
    chk("R8 strobe", {31'h0, offset_load}, 1);
    chk("R8 data", offset_load_data, 32'h8000_0001);
    @(negedge clk);
    chk("R11 offset pulse", {31'h0, offset_load}, 0);
    rd(8'h8C, d); chk("R8 read", d, core_offset);
    rd(8'h90, d); chk("R7 count closed", d, 0);
    wr(8'h80, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(8'h80, 6);
    wr(8'h84, 32'hFFFF_FFFF);
    chk("R10 no strobe", {30'h0, count_load, offset_load}, 0);
    rd(8'h84, d); chk("R10 input reg", d, 0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R10 ctrl kept", d, 6);
    rd(8'h40, d); chk("R10 unmapped", d, 0);
    rd(8'h94, d); chk("R10 past end", d, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_irq();
    t_count();
    t_offset();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule